// File: doc/BRIEF.md
# Ethernet MAC Status and Transmit Control Registers

This block is the byte-wide register slice of a small Ethernet controller. It holds two registers on a simple processor bus: a network status register and a transmit control register. The bus has an address, a write data byte, a read strobe, a write strobe and a read data byte. Read data is combinational from the address and the current register state. Writes and clear-on-read take effect on the rising clock edge that ends the strobe cycle.

The status register shows link speed, link state and receive FIFO overflow as live values taken from the PHY and MAC inputs. It also holds three event flags that stay set once raised: a wakeup flag and one transmit-complete flag for each of the two transmit packet slots. These event flags are set by single-cycle input pulses. Software clears them either by reading the status register or by writing 1 to the flag's bit.

There are two resets. The asynchronous power-on reset clears everything. The synchronous software reset clears the transmit flags and the transmit control bits but leaves the wakeup flag as it was. The transmit control bits go out to the MAC datapath as individual signals.

Top module: `eth_mac_regs`

## Requirements
- R1: Status bit 7 shows `phy_speed_10` (0 means 100 Mbps, 1 means 10 Mbps) and bit 6 shows `phy_link_ok` (1 means link up), both live. Bit 7 is defined only while bit 6 is 1.
- R2: Status bit 1 shows `rx_fifo_ovf` live. Status bits 4 and 0 always read 0.
- R3: Status bit 5 (wakeup) goes to 1 after a cycle with `ev_wake` high and stays at 1. It is cleared by a read of the status register or by a status write with data bit 5 at 1. A status write with bit 5 at 0 leaves it unchanged.
- R4: The wakeup flag is cleared only by `por_n`. A `soft_rst` pulse leaves it unchanged.
- R5: Status bit 2 is the slot-1 done flag, set by `ev_tx_done[0]`. Status bit 3 is the slot-2 done flag, set by `ev_tx_done[1]`. Each flag stays set until a status read, or until a status write with 1 in that flag's own bit. Writing 1 to the other flag's bit does not clear it.
- R6: Both transmit done flags are cleared by `por_n` and by `soft_rst`. When `soft_rst` and a done event arrive in the same cycle, the reset wins.
- R7: When an event pulse arrives in the same cycle as a clearing read or a clearing write, the flag ends up set.
- R8: A status read returns the flag values held before that read. The flags clear at the clock edge that ends the read cycle.
- R9: The transmit control register keeps bits 6..1 of a write. Bits 7 and 0 always read 0. The bits drive these outputs: bit 6 `tx_jabber_dis`, bit 5 `tx_excol_retry`, bit 4 `tx_pad_dis2`, bit 3 `tx_crc_dis2`, bit 2 `tx_pad_dis1`, bit 1 `tx_crc_dis1`.
- R10: The transmit control register and its outputs are cleared to 0 by `por_n` and by `soft_rst`.
- R11: The status register is at address 0x01 and transmit control at 0x02. A read of any other address returns 0. A read or write at any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Read data, combinational from `addr` |
| phy_speed_10 | input | 1 | Live PHY speed, 1 = 10 Mbps |
| phy_link_ok | input | 1 | Live PHY link state, 1 = up |
| rx_fifo_ovf | input | 1 | Live receive FIFO overflow |
| ev_wake | input | 1 | Wakeup event pulse |
| ev_tx_done | input | 2 | Transmit done pulses, bit 0 = slot 1, bit 1 = slot 2 |
| tx_jabber_dis | output | 1 | Disable the 2048-byte jabber timer |
| tx_excol_retry | output | 1 | 1 = keep retrying after excessive collisions, 0 = abort after more than 15 |
| tx_pad_dis2 | output | 1 | Disable padding for slot 2 |
| tx_crc_dis2 | output | 1 | Disable CRC append for slot 2 |
| tx_pad_dis1 | output | 1 | Disable padding for slot 1 |
| tx_crc_dis1 | output | 1 | Disable CRC append for slot 1 |

## Verification
The flag assertions assume that event pulses and strobes are sampled on the clock, and that `soft_rst` is a synchronous level. The live-bit assertions allow for the speed input carrying no meaning while the link is down. The stimulus changes every input on the falling edge and holds each strobe and pulse for exactly one cycle. Speed is compared only while the link input is high: the bench masks bit 7 out of the expected value whenever the link is down. Overlapping cases are driven on purpose in a single cycle: an event together with a clearing read or write, and events together with a software reset.

// File: rtl/eth_mac_regs_pkg.sv
package eth_mac_regs_pkg;
   localparam int REG_W       = 8;
   localparam int NUM_SLOTS   = 2;
   // status bit positions
   localparam int ST_SPEED    = 7;
   localparam int ST_LINK     = 6;
   localparam int ST_WAKE     = 5;
   localparam int ST_SLOT0    = 2;   // slot n done flag at ST_SLOT0 + n
   localparam int ST_OVF      = 1;
   // writable bits of the transmit control register
   localparam logic [REG_W-1:0] TXC_WMASK = 8'h7E;
endpackage

// File: rtl/eth_sticky_flag.sv
module eth_sticky_flag
   import eth_mac_regs_pkg::*;
#(
   parameter bit KEEP_ON_SOFT = 1'b0
) (
   input  logic clk,
   input  logic por_n,
   input  logic soft_rst,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   generate
      if (KEEP_ON_SOFT) begin : g_keep
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)      flag_o <= 1'b0;
            else if (set_i)  flag_o <= 1'b1;
            else if (clr_i)  flag_o <= 1'b0;
         end
         // R4
         soft_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
            (soft_rst && !set_i && !clr_i) |=> $stable(flag_o));
      end else begin : g_soft
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)        flag_o <= 1'b0;
            else if (soft_rst) flag_o <= 1'b0;
            else if (set_i)    flag_o <= 1'b1;
            else if (clr_i)    flag_o <= 1'b0;
         end
         // R6
         soft_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
            soft_rst |=> !flag_o);
      end
   endgenerate

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
      (set_i && (KEEP_ON_SOFT || !soft_rst)) |=> flag_o);
   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      (clr_i && !set_i) |=> !flag_o);
   // R5
   rise_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(flag_o) |-> $past(set_i));

endmodule

// File: rtl/eth_txctl_reg.sv
module eth_txctl_reg
   import eth_mac_regs_pkg::*;
#(
   parameter int               W     = REG_W,
   parameter logic [W-1:0]     WMASK = TXC_WMASK
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         soft_rst,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        q <= '0;
      else if (soft_rst) q <= '0;
      else if (we)       q <= wdata & WMASK;
   end

   // R9
   txc_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!we && !soft_rst) |=> $stable(q));
   // R10
   txc_soft_chk: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> (q == '0));

endmodule

// File: rtl/eth_rd_mux.sv
module eth_rd_mux
   import eth_mac_regs_pkg::*;
#(
   parameter int               ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h01,
   parameter logic [ADDR_W-1:0] TXC_ADDR  = 'h02
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  stat,
   input  logic [REG_W-1:0]  txc,
   output logic [REG_W-1:0]  rdata
);

   always_comb begin
      unique case (1'b1)
         (addr == STAT_ADDR): rdata = stat;
         (addr == TXC_ADDR):  rdata = txc;
         default:             rdata = '0;
      endcase
   end

endmodule

// File: rtl/eth_mac_regs.sv
module eth_mac_regs
   import eth_mac_regs_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h01,
   parameter logic [ADDR_W-1:0] TXC_ADDR  = 'h02
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 soft_rst,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [REG_W-1:0]     wdata,
   input  logic                 wr_en,
   input  logic                 rd_en,
   output logic [REG_W-1:0]     rdata,
   input  logic                 phy_speed_10,
   input  logic                 phy_link_ok,
   input  logic                 rx_fifo_ovf,
   input  logic                 ev_wake,
   input  logic [NUM_SLOTS-1:0] ev_tx_done,
   output logic                 tx_jabber_dis,
   output logic                 tx_excol_retry,
   output logic                 tx_pad_dis2,
   output logic                 tx_crc_dis2,
   output logic                 tx_pad_dis1,
   output logic                 tx_crc_dis1
);

   // elaboration-time configuration checks
   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("eth_mac_regs: ADDR_W must be at least 2");
      end
      if (STAT_ADDR == TXC_ADDR) begin : g_bad_map
         $error("eth_mac_regs: register addresses must differ");
      end
      if (ST_SLOT0 + NUM_SLOTS > ST_WAKE - 1) begin : g_bad_slots
         $error("eth_mac_regs: slot flags overlap the wakeup field");
      end
   endgenerate

   logic stat_hit, txc_hit, stat_rd, stat_wr;
   logic wake_q;
   logic [NUM_SLOTS-1:0] done_q;
   logic [REG_W-1:0] stat_v, txc_q;

   assign stat_hit = (addr == STAT_ADDR);
   assign txc_hit  = (addr == TXC_ADDR);
   assign stat_rd  = rd_en & stat_hit;
   assign stat_wr  = wr_en & stat_hit;

   eth_sticky_flag #(.KEEP_ON_SOFT(1'b1)) u_wake (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
      .set_i(ev_wake), .clr_i(stat_rd | (stat_wr & wdata[ST_WAKE])),
      .flag_o(wake_q)
   );

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         eth_sticky_flag #(.KEEP_ON_SOFT(1'b0)) u_done (
            .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
            .set_i(ev_tx_done[s]),
            .clr_i(stat_rd | (stat_wr & wdata[ST_SLOT0+s])),
            .flag_o(done_q[s])
         );
      end
   endgenerate

   always_comb begin
      stat_v                                = '0;
      stat_v[ST_SPEED]                      = phy_speed_10;
      stat_v[ST_LINK]                       = phy_link_ok;
      stat_v[ST_WAKE]                       = wake_q;
      stat_v[ST_SLOT0 +: NUM_SLOTS]         = done_q;
      stat_v[ST_OVF]                        = rx_fifo_ovf;
   end

   eth_txctl_reg #(.W(REG_W), .WMASK(TXC_WMASK)) u_txc (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
      .we(wr_en & txc_hit), .wdata(wdata), .q(txc_q)
   );

   eth_rd_mux #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .TXC_ADDR(TXC_ADDR)) u_mux (
      .addr(addr), .stat(stat_v), .txc(txc_q), .rdata(rdata)
   );

   assign tx_jabber_dis  = txc_q[6];
   assign tx_excol_retry = txc_q[5];
   assign tx_pad_dis2    = txc_q[4];
   assign tx_crc_dis2    = txc_q[3];
   assign tx_pad_dis1    = txc_q[2];
   assign tx_crc_dis1    = txc_q[1];

   // R11
   other_addr_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!stat_hit && !txc_hit) |-> (rdata == '0));
   // R2
   stat_rsvd_chk: assert property (@(posedge clk) disable iff (!por_n)
      stat_hit |-> (rdata[4] == 1'b0 && rdata[0] == 1'b0 && rdata[1] == rx_fifo_ovf));
   // R1
   link_live_chk: assert property (@(posedge clk) disable iff (!por_n)
      (stat_hit && phy_link_ok) |-> (rdata[7:6] == {phy_speed_10, 1'b1}));
   // R8
   read_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
      (stat_rd && !ev_wake) |=> (rdata[ST_WAKE] == 1'b0 || !stat_hit));

endmodule

// File: tb/tb_eth_mac_regs.sv
module tb_eth_mac_regs;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   logic       por_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] addr = 8'h00, wdata = 8'h00;
   logic [7:0] rdata;
   logic       phy_speed_10 = 1'b0, phy_link_ok = 1'b1, rx_fifo_ovf = 1'b0;
   logic       ev_wake = 1'b0;
   logic [1:0] ev_tx_done = 2'b00;
   logic       tx_jabber_dis, tx_excol_retry, tx_pad_dis2, tx_crc_dis2, tx_pad_dis1, tx_crc_dis1;

   eth_mac_regs dut (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
      .phy_speed_10(phy_speed_10), .phy_link_ok(phy_link_ok), .rx_fifo_ovf(rx_fifo_ovf),
      .ev_wake(ev_wake), .ev_tx_done(ev_tx_done),
      .tx_jabber_dis(tx_jabber_dis), .tx_excol_retry(tx_excol_retry),
      .tx_pad_dis2(tx_pad_dis2), .tx_crc_dis2(tx_crc_dis2),
      .tx_pad_dis1(tx_pad_dis1), .tx_crc_dis1(tx_crc_dis1)
   );

   typedef struct {
      bit         ports;   // 0: compare rdata, 1: compare transmit control outputs
      logic [7:0] exp;
      logic [7:0] mask;
      string      tag;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    checks = 0, errors = 0;
   bit    done = 1'b0;

   // monitor: pops expectations and compares against the design
   initial begin
      forever begin
         @(mon_ev);
         #1;
         if (q.size() != 0) begin
            item_t it;
            logic [7:0] obs;
            it  = q.pop_front();
            obs = it.ports ? {2'b00, tx_jabber_dis, tx_excol_retry, tx_pad_dis2,
                              tx_crc_dis2, tx_pad_dis1, tx_crc_dis1} : rdata;
            checks++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
               errors++;
               $display("FAIL %s: actual=%02h expected=%02h (mask %02h)",
                        it.tag, obs, it.exp, it.mask);
            end
         end
      end
   end

   // ev = {wake, slot2, slot1}
   task automatic drive_ev(input logic [2:0] ev);
      ev_wake    = ev[2];
      ev_tx_done = ev[1:0];
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input logic [7:0] mask,
                     input string tag, input logic [2:0] ev = 3'b000);
      item_t it;
      @(negedge clk);
      addr = a; rd_en = 1'b1; drive_ev(ev);
      it.ports = 1'b0; it.exp = exp; it.mask = mask; it.tag = tag;
      q.push_back(it);
      ->mon_ev;
      @(posedge clk); #1;
      rd_en = 1'b0; drive_ev(3'b000);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [2:0] ev = 3'b000);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1; drive_ev(ev);
      @(posedge clk); #1;
      wr_en = 1'b0; drive_ev(3'b000);
   endtask

   task automatic pulse(input logic [2:0] ev, input logic sr = 1'b0);
      @(negedge clk);
      drive_ev(ev); soft_rst = sr;
      @(posedge clk); #1;
      drive_ev(3'b000); soft_rst = 1'b0;
   endtask

   task automatic chk_ports(input logic [5:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      it.ports = 1'b1; it.exp = {2'b00, exp}; it.mask = 8'h3F; it.tag = tag;
      q.push_back(it);
      ->mon_ev;
      @(posedge clk); #1;
   endtask

   task automatic power_on_reset();
      @(negedge clk); por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      power_on_reset();
      // reset state, R1 live link up at 100 Mbps
      rd(8'h01, 8'h40, 8'hFF, "R1 reset status");
      rd(8'h02, 8'h00, 8'hFF, "R10 reset txctl");
      chk_ports(6'b000000, "R10 reset outputs");

      // R1 R2 live bits
      phy_speed_10 = 1'b1; rx_fifo_ovf = 1'b1;
      rd(8'h01, 8'hC2, 8'hFF, "R1 R2 speed10 link ovf");
      phy_link_ok = 1'b0;
      rd(8'h01, 8'h02, 8'h7F, "R1 link down speed ignored");
      phy_link_ok = 1'b1; phy_speed_10 = 1'b0; rx_fifo_ovf = 1'b0;
      rd(8'h01, 8'h40, 8'hFF, "R2 ovf low reserved zero");

      // R3 R8 wakeup sticky, cleared by read
      pulse(3'b100);
      rd(8'h01, 8'h60, 8'hFF, "R8 read shows wake before clear");
      rd(8'h01, 8'h40, 8'hFF, "R3 wake cleared by read");
      // R3 write 0 no effect, write 1 clears
      pulse(3'b100);
      wr(8'h01, 8'h00);
      rd(8'h01, 8'h60, 8'hFF, "R3 write0 keeps wake");
      pulse(3'b100);
      wr(8'h01, 8'h20);
      rd(8'h01, 8'h40, 8'hFF, "R3 write1 clears wake");

      // R5 slot flags
      pulse(3'b011);
      rd(8'h01, 8'h4C, 8'hFF, "R5 both slots done");
      rd(8'h01, 8'h40, 8'hFF, "R5 slots cleared by read");
      pulse(3'b011);
      wr(8'h01, 8'h04);
      rd(8'h01, 8'h48, 8'hFF, "R5 write1 slot1 keeps slot2");

      // R7 set beats clear
      pulse(3'b001);
      wr(8'h01, 8'h04, 3'b001);
      rd(8'h01, 8'h44, 8'hFF, "R7 event beats write1");
      rd(8'h01, 8'h40, 8'hFF, "R7 old value during read with event", 3'b010);
      rd(8'h01, 8'h48, 8'hFF, "R7 event beats read clear");

      // R9 transmit control
      wr(8'h02, 8'h7E);
      rd(8'h02, 8'h7E, 8'hFF, "R9 txctl all writable");
      chk_ports(6'b111111, "R9 outputs all set");
      wr(8'h02, 8'hFF);
      rd(8'h02, 8'h7E, 8'hFF, "R9 reserved bits read 0");
      wr(8'h02, 8'h54);
      rd(8'h02, 8'h54, 8'hFF, "R9 txctl pattern");
      chk_ports(6'b101010, "R9 outputs pattern");

      // R4 R6 R10 soft reset
      pulse(3'b111);
      pulse(3'b000, 1'b1);
      rd(8'h01, 8'h60, 8'hFF, "R4 R6 soft reset keeps wake clears slots");
      rd(8'h02, 8'h00, 8'hFF, "R10 soft reset txctl");
      chk_ports(6'b000000, "R10 soft reset outputs");
      pulse(3'b011, 1'b1);
      rd(8'h01, 8'h40, 8'hFF, "R6 soft reset beats slot events");

      // R11 other addresses
      wr(8'h02, 8'h2A);
      wr(8'h03, 8'hFF);
      rd(8'h02, 8'h2A, 8'hFF, "R11 write elsewhere keeps txctl");
      rd(8'h03, 8'h00, 8'hFF, "R11 read 0x03 is zero");
      rd(8'h00, 8'h00, 8'hFF, "R11 read 0x00 is zero");
      pulse(3'b001);
      wr(8'h09, 8'hFF);
      rd(8'h07, 8'h00, 8'hFF, "R11 read 0x07 is zero");
      rd(8'h01, 8'h44, 8'hFF, "R11 other access keeps flag");

      // R4 R10 power-on reset clears wake and txctl
      pulse(3'b100);
      wr(8'h02, 8'h7E);
      power_on_reset();
      rd(8'h01, 8'h40, 8'hFF, "R4 POR clears wake");
      rd(8'h02, 8'h00, 8'hFF, "R10 POR clears txctl");

      @(negedge clk); @(negedge clk);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule